// File: doc/BRIEF.md
# Banked Read/Write Memory with Stall-Safe Read Routing

This block is a word-addressed memory built from many small RAM banks. It accepts one request per cycle on a valid/ready request port. A request is either a write or a read. The upper address bits pick a bank and the lower bits pick a word inside that bank. Reads return their data in request order on a valid/ready response port. Writes complete silently.

Each read passes through two registered stages. The first stage is the bank's registered output, together with a bank-index tag held in a stage register. The second stage is the output multiplexer, which steers the tagged bank's word into a small response buffer. The tag stage only advances when the buffer can take its result, and it never runs free.

A two-state flow controller limits intake. In **ST_OPEN** it accepts requests. It moves to **ST_THROTTLE** when the reads in flight plus the buffered responses would fill the buffer. It returns to **ST_OPEN** as soon as that total drops below the buffer depth. Because of this, no result can ever be overwritten or dropped, and writes queue behind stalled reads.

Top module: `banked_ram`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1.
- R2: A write stores req_wdata at bank req_addr[10:5], word req_addr[4:0]. A later read of the same address returns that value.
- R3: A read accepted in cycle c, with nothing in flight and an empty buffer, presents rsp_valid with its data in cycle c+2.
- R4: While rsp_ready is held at 1, req_ready stays 1, so one request is accepted every cycle.
- R5: Read responses come out in request order, each exactly once, with correct data under any pattern of rsp_ready stalls.
- R6: With rsp_ready held at 0, exactly 4 reads (the buffer depth) are accepted, and then req_ready drops to 0.
- R7: A write never produces a response.
- R8: While req_ready is 0, a presented write is not taken and has no effect on the response stream.
- R9: A read of bank index 56 to 63 returns 0 with rsp_valid asserted. A write to those banks has no effect.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Bank index in [10:5], word in [4:0] |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data, oldest first |

## Verification
Suppose the routing tag is lost or advanced during a stall. The fault then shows as a wrong or zero word at rsp_data on the very next handshake for the affected read, and every later read in the stream is shifted by one. Suppose instead the credit count drifts. Then either req_ready stays high past the fourth unread response, which shows as a lost word once draining starts, or it stays low with an empty pipeline, which shows within one cycle as lost throughput. A long run that issues a request every cycle against a slow, random consumer, followed by an exact comparison of each response, exposes both faults.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

    typedef enum logic [0:0] {
        ST_OPEN     = 1'b0,
        ST_THROTTLE = 1'b1
    } flow_state_t;

endpackage

// File: rtl/banked_ram_bank.sv
module banked_ram_bank #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 8,
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wdata;
        end
    end

    // registered output holds its value when no read is launched
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata <= cells[addr];
        end
    end

endmodule

// File: rtl/banked_ram_tagpipe.sv
module banked_ram_tagpipe #(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BANK_W-1:0] in_bank,
    input  logic              advance,
    output logic              out_valid,
    output logic [BANK_W-1:0] out_bank
);

    logic load;

    // the stage refills only when it is empty or its content moves on
    always_comb begin
        load = advance || !out_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bank  <= '0;
        end else if (load) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bank <= in_bank;
            end
        end
    end

endmodule

// File: rtl/banked_ram_rspfifo.sv
module banked_ram_rspfifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty     = (count == '0);
        full      = (count == CNT_W'(DEPTH));
        head_data = slots[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/banked_ram_ctrl.sv
module banked_ram_ctrl
    import banked_ram_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_read,
    input  logic             s1_valid,
    input  logic             s1_adv,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] count,
    output logic             req_ready
);

    flow_state_t state;
    flow_state_t state_nxt;
    logic        s1_nxt;
    logic [CNT_W:0] occ_nxt;

    // occupancy that will hold after this edge: buffered words plus reads in flight
    always_comb begin
        s1_nxt  = acc_read || (s1_valid && !s1_adv);
        occ_nxt = {1'b0, count} + (CNT_W+1)'(push) - (CNT_W+1)'(pop)
                + (CNT_W+1)'(s1_nxt);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (occ_nxt >= (CNT_W+1)'(DEPTH)) begin
                    state_nxt = ST_THROTTLE;
                end
            end
            ST_THROTTLE: begin
                if (occ_nxt < (CNT_W+1)'(DEPTH)) begin
                    state_nxt = ST_OPEN;
                end
            end
            default: state_nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_OPEN:     req_ready = 1'b1;
            ST_THROTTLE: req_ready = 1'b0;
            default:     req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/banked_ram.sv
module banked_ram #(
    parameter int NUM_BANKS  = 56,
    parameter int BANK_WORDS = 32,
    parameter int DATA_W     = 8,
    parameter int RSP_DEPTH  = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int WORD_W = $clog2(BANK_WORDS),
    localparam int ADDR_W = BANK_W + WORD_W,
    localparam int CNT_W  = $clog2(RSP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data
);

    logic              accept;
    logic              acc_read;
    logic              acc_write;
    logic [BANK_W-1:0] req_bank;
    logic [WORD_W-1:0] req_word;

    logic              s1_valid;
    logic [BANK_W-1:0] s1_bank;
    logic              s1_adv;

    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0] mux_data;

    logic              push;
    logic              pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CNT_W-1:0]  fifo_count;

    always_comb begin
        req_bank  = req_addr[ADDR_W-1:WORD_W];
        req_word  = req_addr[WORD_W-1:0];
        accept    = req_valid && req_ready;
        acc_read  = accept && !req_write;
        acc_write = accept && req_write;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_hit;
        logic rd_hit;

        always_comb begin
            wr_hit = acc_write && (req_bank == BANK_W'(b));
            rd_hit = acc_read && (req_bank == BANK_W'(b));
        end

        banked_ram_bank #(
            .WORDS  (BANK_WORDS),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .wr_en (wr_hit),
            .rd_en (rd_hit),
            .addr  (req_word),
            .wdata (req_wdata),
            .rdata (bank_rdata[b])
        );
    end

    banked_ram_tagpipe #(
        .BANK_W (BANK_W)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_read),
        .in_bank   (req_bank),
        .advance   (s1_adv),
        .out_valid (s1_valid),
        .out_bank  (s1_bank)
    );

    // steer the tagged bank; indices past the last bank read as zero
    always_comb begin
        mux_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (s1_bank == BANK_W'(i)) begin
                mux_data = bank_rdata[i];
            end
        end
    end

    always_comb begin
        pop    = rsp_valid && rsp_ready;
        s1_adv = !fifo_full || pop;
        push   = s1_valid && s1_adv;
    end

    banked_ram_rspfifo #(
        .DEPTH  (RSP_DEPTH),
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (mux_data),
        .pop       (pop),
        .head_data (rsp_data),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_comb begin
        rsp_valid = !fifo_empty;
    end

    banked_ram_ctrl #(
        .DEPTH (RSP_DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_read  (acc_read),
        .s1_valid  (s1_valid),
        .s1_adv    (s1_adv),
        .push      (push),
        .pop       (pop),
        .count     (fifo_count),
        .req_ready (req_ready)
    );

endmodule

// File: rtl/banked_ram_chk.sv
module banked_ram_chk #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              s1_valid,
    input logic              s1_adv,
    input logic [CNT_W-1:0]  fifo_count
);

    // R6
    occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_count) + int'(s1_valid)) <= DEPTH);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_adv) |-> !(req_valid && req_ready && !req_write));

    // R3
    read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (s1_valid && s1_adv));

    // R7
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !s1_valid);

endmodule

bind banked_ram banked_ram_chk #(
    .DEPTH  (RSP_DEPTH),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .s1_valid   (s1_valid),
    .s1_adv     (s1_adv),
    .fifo_count (fifo_count)
);

// File: tb/banked_ram_test.sv
`timescale 1ns/1ps
module banked_ram_test;

    localparam int NB    = 56;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [10:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [7:0]  rsp_data;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    int stall_cycles = 0;
    logic [7:0] model [2048];
    logic [7:0] expq [$];

    always #2 clk = ~clk;

    banked_ram uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    function automatic bit in_range(input logic [10:0] a);
        return int'(a[10:5]) < NB;
    endfunction

    function automatic logic [7:0] expect_read(input logic [10:0] a);
        return in_range(a) ? model[a] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, resolve handshakes just before the next rising edge
    task automatic tick(input logic v, input logic w, input logic [10:0] a,
                        input logic [7:0] d, input logic rr);
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        rsp_ready = rr;
        #1;
        if (rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7", int'(rsp_data), -1);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(rsp_data === e, "R5", int'(rsp_data), int'(e));
            end
        end
        if (req_valid && !req_ready) stall_cycles++;
        if (req_valid && req_ready) begin
            accepted++;
            if (req_write) begin
                if (in_range(a)) model[a] = d;
            end else begin
                expq.push_back(expect_read(a));
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [10:0] rnd_addr();
        logic [5:0] b;
        logic [4:0] wd;
        b  = 6'($urandom_range(0, 63));
        wd = 5'($urandom_range(0, 3));
        return {b, wd};
    endfunction

    initial begin
        #(150000 * 4);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1", int'(req_ready), 1);

        // R2 preload every used word; R7 no response from writes
        for (int b = 0; b < NB; b++) begin
            for (int wd = 0; wd < 4; wd++) begin
                tick(1'b1, 1'b1, {6'(b), 5'(wd)}, 8'($urandom_range(1, 255)), 1'b1);
            end
        end
        tick(1'b0, 1'b0, '0, '0, 1'b1);
        tick(1'b0, 1'b0, '0, '0, 1'b1);
        check(rsp_valid == 1'b0, "R7", int'(rsp_valid), 0);

        // R3 latency of two cycles
        begin
            logic [10:0] a;
            logic [7:0] e;
            a = {6'd3, 5'd2};
            e = model[a];
            tick(1'b1, 1'b0, a, '0, 1'b1);
            check(rsp_valid == 1'b0, "R3", int'(rsp_valid), 0);
            tick(1'b0, 1'b0, '0, '0, 1'b0);
            check(rsp_valid == 1'b1, "R3", int'(rsp_valid), 1);
            check(rsp_data == e, "R2", int'(rsp_data), int'(e));
            tick(1'b0, 1'b0, '0, '0, 1'b1);
        end

        // R2 overwrite then read back
        tick(1'b1, 1'b1, {6'd10, 5'd1}, 8'hA5, 1'b1);
        tick(1'b1, 1'b0, {6'd10, 5'd1}, '0, 1'b1);
        tick(1'b0, 1'b0, '0, '0, 1'b0);
        check(rsp_valid && rsp_data == 8'hA5, "R2", int'(rsp_data), 8'hA5);
        tick(1'b0, 1'b0, '0, '0, 1'b1);

        // R6 saturation with a stalled consumer
        accepted = 0;
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, {6'(i), 5'd0}, '0, 1'b0);
        check(accepted == DEPTH, "R6", accepted, DEPTH);
        check(req_ready == 1'b0, "R6", int'(req_ready), 0);

        // R8 and R10: a write held against a closed port
        begin
            logic [7:0] held;
            held = rsp_data;
            accepted = 0;
            for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, {6'd0, 5'd0}, 8'h3C, 1'b0);
            check(accepted == 0, "R8", accepted, 0);
            check(rsp_valid && rsp_data == held, "R10", int'(rsp_data), int'(held));
        end
        tick(1'b0, 1'b0, '0, '0, 1'b1);
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, '0, '0, 1'b1);
        check(expq.size() == 0, "R5", expq.size(), 0);

        // R9 banks past the end read zero, writes ignored
        tick(1'b1, 1'b1, {6'd60, 5'd1}, 8'hFF, 1'b1);
        tick(1'b1, 1'b0, {6'd60, 5'd1}, '0, 1'b1);
        tick(1'b0, 1'b0, '0, '0, 1'b0);
        check(rsp_valid == 1'b1 && rsp_data == 8'h00, "R9", int'(rsp_data), 0);
        tick(1'b0, 1'b0, '0, '0, 1'b1);

        // R4 full throughput
        stall_cycles = 0;
        accepted = 0;
        for (int i = 0; i < 300; i++)
            tick(1'b1, 1'($urandom_range(0, 1)), rnd_addr(), 8'($urandom), 1'b1);
        check(stall_cycles == 0, "R4", stall_cycles, 0);
        check(accepted == 300, "R4", accepted, 300);

        // R5 request every cycle against a slow random consumer
        for (int i = 0; i < 4000; i++)
            tick(1'b1, 1'($urandom_range(0, 3) == 0), rnd_addr(), 8'($urandom),
                 1'($urandom_range(0, 3) == 0));
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, '0, '0, 1'b1);
        check(expq.size() == 0, "R5", expq.size(), 0);
        check(rsp_valid == 1'b0, "R5", int'(rsp_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule